// File: doc/BRIEF.md
# Configurable Booth Multiplier

A signed multiplier whose partial products come from radix-4 Booth recoding of the multiplier operand. A two-bit mode input chooses how the partial-product array is used:

- as one 16x16 multiply;
- as one 8x8 multiply on the low operand bytes;
- as two independent 8x8 multiplies, one per byte lane, computed in the same cycle.

In the 16x16 configuration an optional truncation input rounds the product and clears its low byte. This trades a bounded loss of precision for less switching in the low columns.

Range-detection logic examines both operands on every cycle. When the upper bits of the multiplier are only sign extension, the upper half of the Booth rows is forced to zero. When the upper bits of the multiplicand are only sign extension, the multiplicand fed to the rows is rebuilt from its low byte, so its upper bits stay frozen. Both forms of guarding leave the result exact. The result is captured in a single output register, one cycle after the input is accepted.

Top module: `cbm_mult`

## Requirements
- R1: With mode 00, the product is the exact signed 32-bit product of op_a and op_b, both read as signed 16-bit values.
- R2: With mode 01, the product is the signed product of op_a[7:0] and op_b[7:0], sign-extended to 32 bits. Operand bits [15:8] have no effect.
- R3: With mode 10, product[15:0] is the signed 16-bit product of the low operand bytes and product[31:16] is the signed 16-bit product of the high operand bytes. No carry or sign passes between the two halves.
- R4: Mode 11 gives the same result as mode 00.
- R5: With mode 00 and trunc_en high, the product equals the exact product plus 128 with bits [7:0] cleared, so it differs from the exact product by less than 256.
- R6: trunc_en has no effect in modes 01 and 10.
- R7: When op_b[15:7] are all equal or op_a[15:7] are all equal, the 16x16 result is still exact, and the upper four Booth rows contribute zero whenever op_b[15:7] are all equal.
- R8: out_valid is high in exactly the cycle after in_valid was high, and that cycle carries the result of the accepted operands.
- R9: While in_valid is low, product keeps its last value.
- R10: A synchronous active-high rst clears product to zero and out_valid to low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | 00 wide 16x16, 01 single 8x8, 10 twin 8x8, 11 same as 00 |
| trunc_en | input | 1 | Round and drop the low product byte (wide mode only) |
| op_a | input | 16 | Multiplicand (two byte lanes in twin mode) |
| op_b | input | 16 | Multiplier, Booth-recoded (two byte lanes in twin mode) |
| out_valid | output | 1 | Product register holds a fresh result |
| product | output | 32 | Registered product |

## Verification
The bench builds the block with the default width of 16. This gives four Booth rows per byte lane, which puts the lane split, the restarted Booth group at the lane boundary and the guard thresholds at bit 7 all within reach of a few hand-picked operands. The extreme values -32768, -1, 0, 32767, -128 and 127 are crossed in every mode. Small sign-extended operands exercise both guards, and random operands run back to back exercise the single-cycle pipeline. The rounding bound is checked against the exact product for every truncated result.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE   = 2'b00,
    MODE_NARROW = 2'b01,
    MODE_TWIN   = 2'b10,
    MODE_ALIAS  = 2'b11
  } cbm_mode_e;

  // One radix-4 digit: sign, and magnitude one or two (neither means zero).
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

  function automatic bdig_t booth_dec(input logic [2:0] g);
    bdig_t d;
    d = '0;
    case (g)
      3'b001, 3'b010: d.one = 1'b1;
      3'b011:         d.two = 1'b1;
      3'b100:         begin d.neg = 1'b1; d.two = 1'b1; end
      3'b101, 3'b110: begin d.neg = 1'b1; d.one = 1'b1; end
      default:        d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cbm_range_guard.sv
// Flags an operand whose upper part is only a copy of bit HALF-1.
module cbm_range_guard #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic         is_small
);
  localparam int HALF = W / 2;

  logic [W-HALF:0] top;

  assign top      = val[W-1:HALF-1];
  assign is_small = (&top) | ~(|top);
endmodule

// File: rtl/cbm_booth_row.sv
// One Booth partial-product row, sign-extended to PW bits and not yet shifted.
module cbm_booth_row
  import cbm_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = 32
) (
  input  logic [2:0]    grp,
  input  logic [W:0]    mcand,
  input  logic          en,
  output logic [PW-1:0] pp
);
  bdig_t         dig;
  logic [W+1:0]  mag;
  logic [PW-1:0] ext;

  always_comb begin
    dig = booth_dec(grp);
    if (dig.two)      mag = {mcand, 1'b0};
    else if (dig.one) mag = {mcand[W], mcand};
    else              mag = '0;
    ext = {{(PW-W-2){mag[W+1]}}, mag};
    if (!en)          pp = '0;
    else if (dig.neg) pp = ~ext + PW'(1);
    else              pp = ext;
  end
endmodule

// File: rtl/cbm_mult.sv
module cbm_mult
  import cbm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     mode,
  input  logic           trunc_en,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int HALF  = W / 2;
  localparam int ROWS  = W / 2;
  localparam int LROWS = ROWS / 2;
  localparam int PW    = 2 * W;
  localparam logic [PW-1:0] RND_BIAS = PW'(1) << (HALF - 1);
  localparam logic [PW-1:0] LOW_MASK = (PW'(1) << HALF) - PW'(1);

  cbm_mode_e md;
  logic      wide, narrow, twin;
  logic      a_small, b_small;
  logic      hi_rows_on;
  logic [W:0] mc_wide, mc_lo, mc_hi, lane_lo_a, lane_hi_a;
  logic [W:0] b_ext;
  logic [PW-1:0] row_pp [ROWS];
  logic [PW-1:0] row_sh [ROWS];
  logic [PW-1:0] sum_lo, sum_hi, exact_wide, rounded, next_prod;

  assign md     = cbm_mode_e'(mode);
  assign wide   = (md == MODE_WIDE) || (md == MODE_ALIAS);
  assign narrow = (md == MODE_NARROW);
  assign twin   = (md == MODE_TWIN);

  cbm_range_guard #(.W(W)) u_guard_a (.val(op_a), .is_small(a_small));
  cbm_range_guard #(.W(W)) u_guard_b (.val(op_b), .is_small(b_small));

  // Upper rows run in twin mode, and in wide mode unless the multiplier is small.
  assign hi_rows_on = twin | (wide & ~b_small);

  assign lane_lo_a = {{(HALF+1){op_a[HALF-1]}}, op_a[HALF-1:0]};
  assign lane_hi_a = {{(HALF+1){op_a[W-1]}}, op_a[W-1:HALF]};
  assign mc_wide   = a_small ? lane_lo_a : {op_a[W-1], op_a};
  assign mc_lo     = wide ? mc_wide : lane_lo_a;
  assign mc_hi     = twin ? lane_hi_a : (wide ? mc_wide : '0);
  assign b_ext     = {op_b, 1'b0};

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [2:0] grp;
    logic       en;
    if (i < LROWS) begin : g_low
      assign grp = b_ext[2*i+2:2*i];
      assign en  = 1'b1;
      cbm_booth_row #(.W(W), .PW(PW)) u_row (
        .grp(grp), .mcand(mc_lo), .en(en), .pp(row_pp[i]));
      assign row_sh[i] = row_pp[i] << (2*i);
    end else begin : g_high
      if (i == LROWS) begin : g_edge
        // the high lane restarts Booth recoding with an implied zero below it
        assign grp = twin ? {op_b[HALF+1], op_b[HALF], 1'b0} : b_ext[2*i+2:2*i];
      end else begin : g_mid
        assign grp = b_ext[2*i+2:2*i];
      end
      assign en = hi_rows_on;
      cbm_booth_row #(.W(W), .PW(PW)) u_row (
        .grp(grp), .mcand(mc_hi), .en(en), .pp(row_pp[i]));
      assign row_sh[i] = twin ? (row_pp[i] << (2*(i-LROWS))) : (row_pp[i] << (2*i));
    end
  end

  always_comb begin
    sum_lo = '0;
    sum_hi = '0;
    for (int i = 0; i < LROWS; i++)    sum_lo = sum_lo + row_sh[i];
    for (int i = LROWS; i < ROWS; i++) sum_hi = sum_hi + row_sh[i];
    exact_wide = sum_lo + sum_hi;
    rounded    = (exact_wide + RND_BIAS) & ~LOW_MASK;
    if (twin)        next_prod = {sum_hi[W-1:0], sum_lo[W-1:0]};
    else if (narrow) next_prod = sum_lo;
    else             next_prod = trunc_en ? rounded : exact_wide;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      product   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) product <= next_prod;
    end
  end

  // R8: valid follows the accepted input by exactly one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9: product holds when nothing is accepted
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(product));
  // R10: reset clears the output register
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && product == '0));
  // R5: truncated results have a clear low byte
  a_r5_trunc_low_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide && trunc_en) |=> (product[HALF-1:0] == '0));
  // R2: single narrow result is a sign extension of a 16-bit value
  a_r2_narrow_sext: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow) |=> ((&product[PW-1:W-1]) || !(|product[PW-1:W-1])));
  // R7: a guarded multiplier leaves the upper rows silent
  a_r7_guard_rows_idle: assert property (@(posedge clk) disable iff (rst)
    (wide && b_small) |-> (sum_hi == '0));
endmodule

// File: tb/cbm_mult_bench.sv
`timescale 1ns/1ps
module cbm_mult_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        trunc_en = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [31:0] product;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_exp = '0;

  logic [31:0] exp_q[$];
  logic [31:0] exact_q[$];
  logic        tr_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  cbm_mult u_cbm_mult (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .trunc_en(trunc_en),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .product(product));

  function automatic logic [31:0] ref_mult(input logic [1:0] m, input logic tr,
                                           input logic [15:0] a, input logic [15:0] b);
    longint p, q;
    case (m)
      2'b01: begin
        p = longint'($signed(a[7:0])) * longint'($signed(b[7:0]));
        return p[31:0];
      end
      2'b10: begin
        p = longint'($signed(a[7:0])) * longint'($signed(b[7:0]));
        q = longint'($signed(a[15:8])) * longint'($signed(b[15:8]));
        return {q[15:0], p[15:0]};
      end
      default: begin
        p = longint'($signed(a)) * longint'($signed(b));
        if (tr) p = (p + 128) & ~64'hFF;
        return p[31:0];
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] m, input logic tr, input logic [15:0] a,
                      input logic [15:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1; mode = m; trunc_en = tr; op_a = a; op_b = b;
    last_exp = ref_mult(m, tr, a, b);
    exp_q.push_back(last_exp);
    exact_q.push_back(ref_mult(2'b00, 1'b0, a, b));
    tr_q.push_back(tr && (m == 2'b00 || m == 2'b11));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; op_a = op_a + 16'h1357; op_b = ~op_b; trunc_en = ~trunc_en;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: out_valid with no pending item, got %h expected none", product);
      end else begin
        logic [31:0] e, x;
        logic        t;
        string       g;
        longint      diff;
        e = exp_q.pop_front(); x = exact_q.pop_front();
        t = tr_q.pop_front();  g = tag_q.pop_front();
        check(g, product, e);
        if (t) begin
          diff = longint'($signed(product)) - longint'($signed(x));
          checks++;
          if (diff >= 256 || diff <= -256) begin
            errors++;
            $display("FAIL R5: error bound, got %h expected within 255 of %h", product, x);
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  logic [15:0] cw [6] = '{16'h8000, 16'hFFFF, 16'h0000, 16'h7FFF, 16'hFF80, 16'h007F};
  logic [7:0]  cb [6] = '{8'h80, 8'hFF, 8'h00, 8'h7F, 8'h01, 8'h05};

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset product", product, 32'h0);
    check("R10 reset valid", {31'h0, out_valid}, 32'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        send(2'b00, 1'b0, cw[i], cw[j], "R1 corner");
        send(2'b00, 1'b1, cw[i], cw[j], "R5 corner");
        send(2'b01, 1'b0, {8'hA5, cb[i]}, {8'h3C, cb[j]}, "R2 corner");
        send(2'b10, 1'b0, {cb[j], cb[i]}, {cb[i], cb[j]}, "R3 corner");
      end
    send(2'b10, 1'b0, 16'h0001, 16'h02FF, "R3 lane isolation");
    send(2'b10, 1'b0, 16'h8080, 16'h8080, "R3 both lanes max");
    send(2'b11, 1'b0, 16'h8000, 16'h8000, "R4 alias");
    send(2'b11, 1'b0, 16'h1234, 16'hFEDC, "R4 alias");
    send(2'b01, 1'b1, 16'hFF85, 16'h7781, "R6 narrow trunc");
    send(2'b10, 1'b1, 16'h7F85, 16'h8181, "R6 twin trunc");
    send(2'b00, 1'b0, 16'hFFFD, 16'h0005, "R7 both small");
    send(2'b00, 1'b0, 16'h8000, 16'hFF80, "R7 multiplier small");
    send(2'b00, 1'b0, 16'h007F, 16'h8001, "R7 multiplicand small");
    send(2'b00, 1'b0, 16'h0080, 16'h007F, "R7 just outside guard");
    send(2'b00, 1'b0, 16'h1234, 16'h0040, "R7 positive small");
    for (int n = 0; n < 200; n++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom); rb = 16'($urandom);
      send(2'($urandom % 4), 1'($urandom), ra, rb, "R8 random");
    end
    idle(3);
    // R8: every accepted item produced exactly one result
    check("R8 drained", 32'(exp_q.size()), 32'h0);
    // R9: product held while idle with changing inputs
    check("R9 hold value", product, last_exp);
    check("R9 hold valid", {31'h0, out_valid}, 32'h0);
    // R10: mid-run reset
    send(2'b00, 1'b0, 16'h7FFF, 16'h7FFF, "R1 before reset");
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R10 mid reset product", product, 32'h0);
    check("R10 mid reset valid", {31'h0, out_valid}, 32'h0);
    rst = 1'b0;
    idle(2);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule